// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the active feedback divider (M), post divider (N) and test-select (T) settings of a frequency synthesizer. Two ports can write them. The parallel port presents M and N on wide inputs and is governed by a strobe. While the strobe is low, the active M and N follow the inputs. When the strobe rises, the values present at that moment are kept.

The serial port moves a 14-bit word into a shift register on rising edges of a serial clock. This happens only while the parallel strobe is high. The word is sent T first, then N, then M, each field with its most significant bit first. A falling edge on the serial transfer input copies the three fields into the active registers. The oldest bit in the shift register is presented on a serial output so that a test multiplexer can select it.

The serial clock, strobe and transfer inputs are sampled by the system clock, so each of them must stay at a level for at least one clock period. Every output is a register.

Top module: `cfg_divload`

## Requirements
- R1: A synchronous reset clears the shift register, active M, active N and active T to zero, so `ser_out` reads 0 after reset.
- R2: While `par_strobe` is low, `act_m` and `act_n` take `par_m` and `par_n` one clock after each sample, and `act_t` reads 000.
- R3: On a rising edge of `par_strobe`, the block keeps the parallel values sampled in that clock. While the strobe stays high and no transfer occurs, changes on `par_m` and `par_n` have no effect.
- R4: A rising edge of `ser_clk` while `par_strobe` is high shifts the shift register one place toward its MSB and inserts `ser_din` at bit 0.
- R5: While `par_strobe` is low, `ser_clk` edges leave the shift register unchanged.
- R6: A falling edge of `ser_xfer` while `par_strobe` is high loads the shift register into the active registers. T takes bits 13:11, N takes bits 10:9 and M takes bits 8:0. The first bit sent ends up in bit 13.
- R7: A rising edge of `ser_xfer` has no effect. A transfer while `par_strobe` is low has no effect either, because the parallel port has priority.
- R8: `act_t` is 000 whenever `par_strobe` was low in the previous clock. After the strobe rises, T stays 000 until a serial transfer.
- R9: If more than 14 bits are shifted, only the last 14 remain, and the earliest bits are discarded.
- R10: `ser_out` equals bit 13 of the shift register, which is the oldest bit still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_m | input | 9 | Parallel M value |
| par_n | input | 2 | Parallel N value |
| par_strobe | input | 1 | Parallel strobe: low means follow the inputs, a rising edge captures |
| ser_clk | input | 1 | Serial shift clock, sampled by clk |
| ser_din | input | 1 | Serial data |
| ser_xfer | input | 1 | Serial transfer; its falling edge loads the active registers |
| act_m | output | 9 | Active M divider value |
| act_n | output | 2 | Active N divider value |
| act_t | output | 3 | Active test-select bits |
| ser_out | output | 1 | MSB of the shift register |

## Verification
A wrong bit in the shift register does not show at the ports straight away. It shows on `ser_out` once it has shifted up to bit 13, or on `act_t`, `act_n` and `act_m` one clock after the next transfer edge. For that reason, the bench checks `ser_out` after every shifted bit and checks all three fields after each transfer. A fault in how the active registers pick their source shows within one clock. In that case M or N either follow the parallel inputs while the strobe is high or fail to follow them while it is low, and T is nonzero after a low strobe. The bench changes the parallel inputs in both strobe states to expose these faults.

// File: rtl/cfg_divload_pkg.sv
package cfg_divload_pkg;
  localparam int unsigned DEF_MW = 9;
  localparam int unsigned DEF_NW = 2;
  localparam int unsigned DEF_TW = 3;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_PAR  = 2'd1,
    SRC_SER  = 2'd2
  } load_src_e;
endpackage

// File: rtl/cfgl_edge.sv
module cfgl_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= '0;
    else     sig_q <= sig;
  end

  for (genvar i = 0; i < N; i++) begin : g_det
    assign rise[i] = sig[i] & ~sig_q[i];
    assign fall[i] = ~sig[i] & sig_q[i];
  end
endmodule

// File: rtl/cfgl_shift.sv
module cfgl_shift #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic         sout
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end

  assign sout = q[W-1];

  // R4
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (q == {$past(q[W-2:0]), $past(din)}));

  // R5
  shift_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(q));
endmodule

// File: rtl/cfgl_active.sv
module cfgl_active
  import cfg_divload_pkg::*;
#(
  parameter int unsigned MW = DEF_MW,
  parameter int unsigned NW = DEF_NW,
  parameter int unsigned TW = DEF_TW,
  localparam int unsigned SW = TW + NW + MW
) (
  input  logic          clk,
  input  logic          rst,
  input  load_src_e     src,
  input  logic [MW-1:0] par_m,
  input  logic [NW-1:0] par_n,
  input  logic [SW-1:0] ser_word,
  output logic [MW-1:0] act_m,
  output logic [NW-1:0] act_n,
  output logic [TW-1:0] act_t
);
  logic [TW-1:0] w_t;
  logic [NW-1:0] w_n;
  logic [MW-1:0] w_m;

  assign w_t = ser_word[SW-1 -: TW];
  assign w_n = ser_word[MW +: NW];
  assign w_m = ser_word[MW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_m <= '0;
      act_n <= '0;
      act_t <= '0;
    end else begin
      unique case (src)
        SRC_PAR: begin
          act_m <= par_m;
          act_n <= par_n;
          act_t <= '0;
        end
        SRC_SER: begin
          act_m <= w_m;
          act_n <= w_n;
          act_t <= w_t;
        end
        default: ;
      endcase
    end
  end

  // R2
  par_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_PAR) |=> (act_m == $past(par_m)) && (act_n == $past(par_n)));

  // R8
  test_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_PAR) |=> (act_t == '0));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_HOLD) |=> $stable(act_m) && $stable(act_n) && $stable(act_t));
endmodule

// File: rtl/cfg_divload.sv
module cfg_divload
  import cfg_divload_pkg::*;
#(
  parameter int unsigned MW = DEF_MW,
  parameter int unsigned NW = DEF_NW,
  parameter int unsigned TW = DEF_TW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] par_m,
  input  logic [NW-1:0] par_n,
  input  logic          par_strobe,
  input  logic          ser_clk,
  input  logic          ser_din,
  input  logic          ser_xfer,
  output logic [MW-1:0] act_m,
  output logic [NW-1:0] act_n,
  output logic [TW-1:0] act_t,
  output logic          ser_out
);
  localparam int unsigned SW   = TW + NW + MW;
  localparam int unsigned NSIG = 3;
  localparam int unsigned I_STB = 0;
  localparam int unsigned I_SCK = 1;
  localparam int unsigned I_XFR = 2;

  logic [NSIG-1:0] lvl, rise, fall;
  logic [SW-1:0]   sr;
  logic            shift_en;
  load_src_e       src;

  assign lvl = {ser_xfer, ser_clk, par_strobe};

  cfgl_edge #(.N(NSIG)) i_edge (
    .clk (clk),
    .rst (rst),
    .sig (lvl),
    .rise(rise),
    .fall(fall)
  );

  assign shift_en = rise[I_SCK] & par_strobe;

  cfgl_shift #(.W(SW)) i_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_en(shift_en),
    .din     (ser_din),
    .q       (sr),
    .sout    (ser_out)
  );

  always_comb begin
    if (!par_strobe || rise[I_STB]) src = SRC_PAR;
    else if (fall[I_XFR])           src = SRC_SER;
    else                            src = SRC_HOLD;
  end

  cfgl_active #(.MW(MW), .NW(NW), .TW(TW)) i_active (
    .clk     (clk),
    .rst     (rst),
    .src     (src),
    .par_m   (par_m),
    .par_n   (par_n),
    .ser_word(sr),
    .act_m   (act_m),
    .act_n   (act_n),
    .act_t   (act_t)
  );

  // R8
  strobe_low_t_chk: assert property (@(posedge clk) disable iff (rst)
    !par_strobe |=> (act_t == '0));
endmodule

// File: tb/test_cfg_divload.sv
module test_cfg_divload;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic       par_strobe = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_din = 1'b0;
  logic       ser_xfer = 1'b0;
  logic [8:0] act_m;
  logic [1:0] act_n;
  logic [2:0] act_t;
  logic       ser_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [13:0] model_sr = '0;

  typedef struct {
    string      tag;
    logic [8:0] m;
    logic [1:0] n;
    logic [2:0] t;
    logic       so;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  cfg_divload i_cfg_divload (
    .clk(clk), .rst(rst), .par_m(par_m), .par_n(par_n), .par_strobe(par_strobe),
    .ser_clk(ser_clk), .ser_din(ser_din), .ser_xfer(ser_xfer),
    .act_m(act_m), .act_n(act_n), .act_t(act_t), .ser_out(ser_out)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic push(string tag, logic [8:0] m, logic [1:0] n, logic [2:0] t);
    exp_t e;
    e.tag = tag; e.m = m; e.n = n; e.t = t; e.so = model_sr[13];
    q.push_back(e);
  endtask

  task automatic send_bit(logic b);
    ser_din = b;
    ser_clk = 1'b1;
    if (par_strobe) model_sr = {model_sr[12:0], b};
    cyc();
    ser_clk = 1'b0;
    cyc();
  endtask

  // monitor: compare outputs at falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (act_m !== e.m || act_n !== e.n || act_t !== e.t || ser_out !== e.so) begin
        errors++;
        $display("FAIL %s: got m=%h n=%h t=%b so=%b, expected m=%h n=%h t=%b so=%b",
                 e.tag, act_m, act_n, act_t, ser_out, e.m, e.n, e.t, e.so);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [13:0] word;
    int t_sent;
    repeat (2) cyc();
    rst = 1'b0;
    cyc();
    push("R1 reset state", 9'h000, 2'd0, 3'b000);

    // R2 transparent while strobe low
    par_strobe = 1'b0; par_m = 9'h1A5; par_n = 2'd2;
    cyc(); push("R2 follow a", 9'h1A5, 2'd2, 3'b000);
    par_m = 9'h033; par_n = 2'd1;
    cyc(); push("R2 follow b", 9'h033, 2'd1, 3'b000);

    // R5 serial clocks ignored while strobe low
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    push("R5 no shift when low", 9'h033, 2'd1, 3'b000);

    // R3 capture on rising strobe, then hold
    par_m = 9'h155; par_n = 2'd3; par_strobe = 1'b1;
    cyc(); push("R3 capture", 9'h155, 2'd3, 3'b000);
    par_m = 9'h0AA; par_n = 2'd0;
    cyc(); push("R3 hold ignores inputs", 9'h155, 2'd3, 3'b000);

    // R4 / R10 shift a word, MSB first, check ser_out per bit
    word = {3'b101, 2'b10, 9'h10C};
    for (int i = 13; i >= 0; i--) begin
      send_bit(word[i]);
      push("R4 R10 shift bit", 9'h155, 2'd3, 3'b000);
    end

    // R7 rising edge of transfer does nothing
    ser_xfer = 1'b1;
    cyc(); push("R7 xfer rise ignored", 9'h155, 2'd3, 3'b000);
    // R6 falling edge loads fields
    ser_xfer = 1'b0;
    cyc(); push("R6 transfer fields", 9'h10C, 2'd2, 3'b101);

    // R9 two extra bits push out the oldest
    send_bit(1'b0);
    send_bit(1'b1);
    ser_xfer = 1'b1; cyc();
    ser_xfer = 1'b0; cyc();
    push("R9 overflow keeps last 14", model_sr[8:0], model_sr[10:9], model_sr[13:11]);
    t_sent = model_sr[13:11];
    if (t_sent != 3'b110) begin
      checks++; errors++;
      $display("FAIL R9 bench model: got %b expected 110", t_sent[2:0]);
    end

    // R8 strobe low clears T
    par_m = 9'h1FF; par_n = 2'd3; par_strobe = 1'b0;
    cyc(); push("R8 T cleared low", 9'h1FF, 2'd3, 3'b000);
    // R7 transfer while strobe low has no effect
    ser_xfer = 1'b1; cyc();
    ser_xfer = 1'b0; cyc();
    push("R7 xfer while low ignored", 9'h1FF, 2'd3, 3'b000);
    // R8 T stays zero after strobe rises
    par_strobe = 1'b1;
    cyc(); push("R8 T zero after rise", 9'h1FF, 2'd3, 3'b000);
    par_m = 9'h001;
    cyc(); push("R8 T still zero held", 9'h1FF, 2'd3, 3'b000);

    repeat (3) cyc();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule